// File: doc/BRIEF.md
# Multi-Word Level Interrupt Aggregator

This block is a second-level interrupt controller that gathers up to 128 level-sensitive interrupt lines, arranged in 32-bit groups called words, and folds them onto a small set of parent interrupt outputs. Each word has an enable register and a status register in its own register window on a simple single-cycle register bus. The status register shows the synchronized input level. A parent output is raised when any enabled, pending source that is routed to that parent is active.

Routing is fixed at build time by two parameter masks per word. The map mask is kept per parent and per word, and it chooses which source positions feed which parent. The forward mask picks sources that leave the aggregation path altogether and drive their own pass-through output pin directly. Positions that no map mask covers are treated as having no source. They read as zero and never raise a parent.

Sources have no acknowledge and no clear. Software changes the enables only by rewriting a whole word, using read-modify-write.

Top module: `irq_word_aggregator`

## Requirements
- R1: While reset is held and at the first cycle after it is released, every parent output and every pass-through output is low. The enable register of each word holds that word's forward mask value.
- R2: Word w occupies the byte window starting at w*16 (address bits [5:4] select the word, bits [3:0] the offset). Offset 0x00 is the read/write enable register and offset 0x04 is the read-only status register. Read data is registered and valid in the cycle after the read request.
- R3: Each source passes through a two-flop synchronizer. Status bit b of word w reads the synchronized level of source w*32+b, and reads zero when no parent's map mask covers that position. Status cannot be cleared by any write.
- R4: Parent output p is the registered OR, over all words, of status AND enable AND the map mask of parent p AND NOT the forward mask. It follows a source change within three clock edges.
- R5: A source whose forward bit is set never contributes to any parent output, whatever its enable bit holds.
- R6: Pass-through output w*32+b equals the synchronized level of that source when its forward bit is set, and is zero otherwise. It is registered and is not gated by the enable register.
- R7: A write to offset 0x00 replaces all 32 enable bits of the addressed word with the write data. Other words are left unchanged.
- R8: A write to the status offset changes no enable register, and status keeps showing the input level afterwards.
- R9: A read from an offset other than 0x00 or 0x04, or from a word index at or above the configured word count, returns zero. A write there changes no register.
- R10: A source position covered by no map mask never raises a parent output, even when its enable bit is set and its input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_WORDS*32 | Level-sensitive interrupt sources, source w*32+b at bit w*32+b |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address: [5:4] word index, [3:0] offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| parent_o | output | NUM_PARENTS | Aggregated parent interrupt outputs |
| pass_o | output | NUM_WORDS*32 | Pass-through outputs for forwarded sources |

## Verification
The sources are driven with random 64-bit patterns while the enable words are rewritten at random. Each parent and pass-through output is compared against a model of the routing formula. Random inputs tell apart wrong map slices, a wrong word order and missing enable gating. Directed cases cover the rest. One source that is both forwarded and enabled separates the bypass exclusion from the enable gate. Enabled unmapped positions driven high show whether the status mask leaks into a parent. Writes to the status offset, to an unused offset and to an absent word show whether a mis-decode reaches an enable register.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int WORD_BITS = 32;
  localparam int WIN_BITS  = 4;
  localparam int IDX_BITS  = 2;
  localparam int ADDR_BITS = WIN_BITS + IDX_BITS;
  localparam int MAX_WORDS = 1 << IDX_BITS;

  localparam logic [WIN_BITS-1:0] OFS_ENABLE = 4'h0;
  localparam logic [WIN_BITS-1:0] OFS_STATUS = 4'h4;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_STATUS = 2'd2
  } reg_kind_e;

  function automatic reg_kind_e decode_ofs(input logic [WIN_BITS-1:0] ofs);
    if (ofs == OFS_ENABLE)      return KIND_ENABLE;
    else if (ofs == OFS_STATUS) return KIND_STATUS;
    else                        return KIND_NONE;
  endfunction
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= d_i;
      stable_q <= meta_q;
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/irqagg_word.sv
module irqagg_word #(
  parameter int                                          NUM_PARENTS = 2,
  parameter logic [irqagg_pkg::WORD_BITS-1:0]            FWD         = '0,
  parameter logic [NUM_PARENTS*irqagg_pkg::WORD_BITS-1:0] MAP        = '1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [irqagg_pkg::WORD_BITS-1:0] wdata,
  input  logic [irqagg_pkg::WORD_BITS-1:0] lvl,
  output logic [irqagg_pkg::WORD_BITS-1:0] en_q,
  output logic [irqagg_pkg::WORD_BITS-1:0] status,
  output logic [irqagg_pkg::WORD_BITS-1:0] fwd_lvl,
  output logic [NUM_PARENTS-1:0]           hit
);
  import irqagg_pkg::*;

  localparam int WB = WORD_BITS;

  // Positions that some parent's map mask covers.
  function automatic logic [WB-1:0] covered_bits();
    logic [WB-1:0] acc;
    acc = '0;
    for (int p = 0; p < NUM_PARENTS; p++) acc |= MAP[p*WB +: WB];
    return acc;
  endfunction

  localparam logic [WB-1:0] IMPL = covered_bits();

  always_ff @(posedge clk) begin
    if (rst)        en_q <= FWD;
    else if (wr_en) en_q <= wdata;
  end

  assign status  = lvl & IMPL;
  assign fwd_lvl = lvl & FWD;

  logic [WB-1:0] live;
  assign live = status & en_q & ~FWD;

  for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_par
    assign hit[p] = |(live & MAP[p*WB +: WB]);
  end
endmodule

// File: rtl/irqagg_regbus.sv
module irqagg_regbus #(
  parameter int NUM_WORDS = 2
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic                                       bus_sel,
  input  logic                                       bus_we,
  input  logic [irqagg_pkg::ADDR_BITS-1:0]           bus_addr,
  input  logic [NUM_WORDS*irqagg_pkg::WORD_BITS-1:0] en_all,
  input  logic [NUM_WORDS*irqagg_pkg::WORD_BITS-1:0] status_all,
  output logic [NUM_WORDS-1:0]                       wr_word,
  output logic [irqagg_pkg::WORD_BITS-1:0]           rdata
);
  import irqagg_pkg::*;

  localparam int WB = WORD_BITS;

  logic [IDX_BITS-1:0] idx;
  reg_kind_e           kind;
  logic [WB-1:0]       rd_mux;

  assign idx  = bus_addr[ADDR_BITS-1:WIN_BITS];
  assign kind = decode_ofs(bus_addr[WIN_BITS-1:0]);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_wr
    assign wr_word[w] = bus_sel && bus_we && (kind == KIND_ENABLE)
                        && (idx == IDX_BITS'(w));
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (idx == IDX_BITS'(w)) begin
        if (kind == KIND_ENABLE)      rd_mux = en_all[w*WB +: WB];
        else if (kind == KIND_STATUS) rd_mux = status_all[w*WB +: WB];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    rdata <= '0;
    else if (bus_sel && !bus_we) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_word_aggregator.sv
module irq_word_aggregator #(
  parameter int NUM_WORDS   = 2,
  parameter int NUM_PARENTS = 2,
  parameter logic [NUM_WORDS*32-1:0]             FWD_MASK = '0,
  parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0] MAP_MASK = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_WORDS*32-1:0]  src_i,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [5:0]               bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_PARENTS-1:0]   parent_o,
  output logic [NUM_WORDS*32-1:0]  pass_o
);
  import irqagg_pkg::*;

  localparam int WB  = WORD_BITS;
  localparam int ALL = NUM_WORDS * WB;

  // Slice of MAP_MASK for parent p, word w: [(p*NUM_WORDS+w)*32 +: 32].
  function automatic logic [NUM_PARENTS*WB-1:0] word_map(input int w);
    logic [NUM_PARENTS*WB-1:0] m;
    for (int p = 0; p < NUM_PARENTS; p++)
      m[p*WB +: WB] = MAP_MASK[(p*NUM_WORDS + w)*WB +: WB];
    return m;
  endfunction

  logic [ALL-1:0]         lvl;
  logic [ALL-1:0]         en_all;
  logic [ALL-1:0]         status_all;
  logic [ALL-1:0]         fwd_all;
  logic [NUM_WORDS-1:0]   wr_word;
  logic [NUM_PARENTS-1:0] hit_w [NUM_WORDS];
  logic [NUM_PARENTS-1:0] parent_d;

  irqagg_sync #(.WIDTH(ALL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (lvl)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    irqagg_word #(
      .NUM_PARENTS (NUM_PARENTS),
      .FWD         (FWD_MASK[w*WB +: WB]),
      .MAP         (word_map(w))
    ) u_word (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_word[w]),
      .wdata   (bus_wdata),
      .lvl     (lvl[w*WB +: WB]),
      .en_q    (en_all[w*WB +: WB]),
      .status  (status_all[w*WB +: WB]),
      .fwd_lvl (fwd_all[w*WB +: WB]),
      .hit     (hit_w[w])
    );
  end

  irqagg_regbus #(.NUM_WORDS(NUM_WORDS)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .en_all     (en_all),
    .status_all (status_all),
    .wr_word    (wr_word),
    .rdata      (bus_rdata)
  );

  always_comb begin
    parent_d = '0;
    for (int w = 0; w < NUM_WORDS; w++) parent_d |= hit_w[w];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      parent_o <= '0;
      pass_o   <= '0;
    end else begin
      parent_o <= parent_d;
      pass_o   <= fwd_all;
    end
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int NUM_WORDS   = 2,
  parameter int NUM_PARENTS = 2,
  parameter logic [NUM_WORDS*32-1:0]             FWD_MASK = '0,
  parameter logic [NUM_PARENTS*NUM_WORDS*32-1:0] MAP_MASK = '1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_sel,
  input logic                    bus_we,
  input logic [5:0]              bus_addr,
  input logic [31:0]             bus_rdata,
  input logic [NUM_PARENTS-1:0]  parent_o,
  input logic [NUM_WORDS*32-1:0] pass_o,
  input logic [NUM_WORDS*32-1:0] en_all,
  input logic [NUM_WORDS*32-1:0] lvl
);
  logic bad_rd;
  assign bad_rd = bus_sel && !bus_we &&
                  (!(bus_addr[3:0] == 4'h0 || bus_addr[3:0] == 4'h4) ||
                   int'(bus_addr[5:4]) >= NUM_WORDS);

  // R1: enables come out of reset at the forward mask, outputs quiet.
  a_r1_reset_enable: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (en_all == FWD_MASK && parent_o == '0 && pass_o == '0));

  // R8: status-offset writes leave every enable unchanged.
  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr[3:0] == 4'h4) |=> $stable(en_all));

  // R9: bad offset or absent word reads back zero.
  a_r9_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
    bad_rd |=> (bus_rdata == '0));

  // R6: pass-through never shows a non-forwarded position.
  a_r6_pass_only_fwd: assert property (@(posedge clk) disable iff (rst)
    (pass_o & ~FWD_MASK) == '0);

  for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_par
    localparam logic [NUM_WORDS*32-1:0] PMAP = MAP_MASK[p*NUM_WORDS*32 +: NUM_WORDS*32];
    // R4 R5 R10: a parent rises only from a mapped, enabled, non-forwarded level.
    a_r4_parent_has_cause: assert property (@(posedge clk) disable iff (rst)
      parent_o[p] |-> $past(|(lvl & en_all & PMAP & ~FWD_MASK)));
  end
endmodule

bind irq_word_aggregator irqagg_checker #(
  .NUM_WORDS   (NUM_WORDS),
  .NUM_PARENTS (NUM_PARENTS),
  .FWD_MASK    (FWD_MASK),
  .MAP_MASK    (MAP_MASK)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .parent_o  (parent_o),
  .pass_o    (pass_o),
  .en_all    (en_all),
  .lvl       (lvl)
);

// File: tb/irq_word_aggregator_test.sv
module irq_word_aggregator_test;
  localparam int NW = 2;
  localparam int NP = 2;
  // FWD: word0 bits 0,1 ; word1 bit 16.
  localparam logic [NW*32-1:0] FWD = {32'h0001_0000, 32'h0000_0003};
  // MAP slice (p*NW+w)*32: p0w0, p0w1, p1w0, p1w1.
  localparam logic [NP*NW*32-1:0] MAP =
    {32'hFFFF_0000, 32'h0FF0_0000, 32'h0000_00FF, 32'h0000_FFFF};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW*32-1:0] src_i = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] parent_o;
  logic [NW*32-1:0] pass_o;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] m_en [NW];

  always #4 clk = ~clk;

  irq_word_aggregator #(
    .NUM_WORDS(NW), .NUM_PARENTS(NP), .FWD_MASK(FWD), .MAP_MASK(MAP)
  ) uut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .parent_o(parent_o), .pass_o(pass_o)
  );

  function automatic logic [31:0] map_of(int p, int w);
    return MAP[(p*NW + w)*32 +: 32];
  endfunction

  function automatic logic [31:0] exp_status(int w, logic [NW*32-1:0] s);
    logic [31:0] impl = '0;
    for (int p = 0; p < NP; p++) impl |= map_of(p, w);
    return s[w*32 +: 32] & impl;
  endfunction

  function automatic logic [NP-1:0] exp_parent(logic [NW*32-1:0] s);
    logic [NP-1:0] r = '0;
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < NW; w++)
        if (|(s[w*32 +: 32] & m_en[w] & map_of(p, w) & ~FWD[w*32 +: 32])) r[p] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_src(logic [NW*32-1:0] s);
    @(negedge clk);
    src_i = s;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    check("R1 parent in reset", 64'(parent_o), 64'd0);
    check("R1 pass in reset", pass_o, 64'd0);
    rst = 1'b0;
    for (int w = 0; w < NW; w++) m_en[w] = FWD[w*32 +: 32];
    @(negedge clk);
    check("R1 parent after reset", 64'(parent_o), 64'd0);
    for (int w = 0; w < NW; w++) begin
      bus_read(6'(w*16), rd);
      check("R1 R2 enable reset value", 64'(rd), 64'(FWD[w*32 +: 32]));
    end

    // R5 R6: forwarded, enabled source bypasses parents.
    set_src(64'h0000_0000_0000_0001);
    check("R5 forwarded not in parent", 64'(parent_o), 64'd0);
    check("R6 pass-through follows", pass_o, 64'h1);
    // R6: not gated by enable.
    bus_write(6'h00, 32'h0);
    m_en[0] = 32'h0;
    repeat (2) @(negedge clk);
    check("R6 pass ungated by enable", pass_o, 64'h1);

    // R7: full-word write replaces, other word unchanged.
    bus_write(6'h00, 32'h0000_0100);
    m_en[0] = 32'h0000_0100;
    bus_read(6'h00, rd);
    check("R7 enable readback", 64'(rd), 64'h100);
    bus_read(6'h10, rd);
    check("R7 other word untouched", 64'(rd), 64'(FWD[63:32]));
    set_src(64'h0000_0000_0000_0100);
    check("R4 parent0 from word0 bit8", 64'(parent_o), 64'b01);
    bus_read(6'h04, rd);
    check("R3 status level", 64'(rd), 64'h100);

    // R10: unmapped bits 16..19, 28..31 of word0, enabled and high.
    bus_write(6'h00, 32'hF00F_0000);
    m_en[0] = 32'hF00F_0000;
    set_src(64'h0000_0000_F00F_0000);
    check("R10 unmapped never parent", 64'(parent_o), 64'd0);
    bus_read(6'h04, rd);
    check("R3 unmapped status zero", 64'(rd), 64'h0);

    // R8: status write ignored, status not cleared.
    set_src(64'h0000_0000_0000_0100);
    bus_write(6'h04, 32'hFFFF_FFFF);
    bus_read(6'h00, rd);
    check("R8 enable after status write", 64'(rd), 64'(m_en[0]));
    bus_read(6'h04, rd);
    check("R8 status still level", 64'(rd), 64'h100);

    // R9: bad offset and absent word.
    bus_write(6'h08, 32'hFFFF_FFFF);
    bus_write(6'h20, 32'hFFFF_FFFF);
    bus_read(6'h08, rd);
    check("R9 bad offset read", 64'(rd), 64'h0);
    bus_read(6'h20, rd);
    check("R9 absent word read", 64'(rd), 64'h0);
    bus_read(6'h24, rd);
    check("R9 absent word status read", 64'(rd), 64'h0);
    bus_read(6'h00, rd);
    check("R9 enable0 unchanged", 64'(rd), 64'(m_en[0]));
    bus_read(6'h10, rd);
    check("R9 enable1 unchanged", 64'(rd), 64'(m_en[1]));

    // Random mix.
    for (int i = 0; i < 200; i++) begin
      logic [NW*32-1:0] s;
      if ($urandom_range(0, 2) == 0) begin
        int w = $urandom_range(0, NW-1);
        logic [31:0] d = $urandom();
        bus_write(6'(w*16), d);
        m_en[w] = d;
      end
      s = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) s = s & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      set_src(s);
      check("R4 R5 R10 random parent", 64'(parent_o), 64'(exp_parent(s)));
      check("R6 random pass", pass_o, s & FWD);
      begin
        int w = $urandom_range(0, NW-1);
        bus_read(6'(w*16 + 4), rd);
        check("R3 random status", 64'(rd), 64'(exp_status(w, s)));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule